// File: doc/BRIEF.md
# One-Time-Programmable Array Bulk Transfer Engine

This block moves a run of 32-bit words between a one-time-programmable memory array and an eight-entry FIFO. Software writes a starting cell address, a word count (stored as the number of words minus one) and a 3-bit mode code. In bulk read mode the engine fetches words from the array into the FIFO, and software drains them through a single data port. In bulk program mode software fills the FIFO through the same port, and the engine writes each word to the array. The cell address counts 32-bit halves of 64-bit physical words: bit 0 picks the upper or lower half, and the remaining bits pick the physical word.

The sequencer has four states. SQ_IDLE is used in standby and in the modes that start no transfer. SQ_READ fetches words. SQ_PROG writes words. SQ_DONE holds a finished run until software returns to standby. The transitions are:

- SQ_IDLE to SQ_READ on a bulk-read start, and SQ_IDLE to SQ_PROG on a bulk-program start.
- SQ_READ or SQ_PROG to SQ_DONE when the last word is acknowledged.
- Any state to SQ_IDLE on a standby write.

Top module: `otp_bulk_xfer`

## Requirements
- R1: After reset the mode reads 000 (standby), the remaining count is 0, the FIFO level is 0, ready is 1 and the last-read register is 0.
- R2: Mode codes are 000 standby, 001 direct read, 010 manual program, 011 bulk read, 100 bulk program, 101 to 111 test modes. A mode write takes effect only when the current mode is standby or the written code is standby; otherwise it is ignored. Codes other than 011 and 100 start no array access.
- R3: Entering bulk read or bulk program from standby loads the remaining count with count+1 and the cell address with the start address. Each acknowledged array access presents physical word = address[13:1] and half = address[0], then advances the address by one and lowers the remaining count by one.
- R4: In bulk read the engine requests an array read only while the FIFO is not full. The words enter the FIFO in address order.
- R5: In every mode except bulk program, a port read with a non-empty FIFO pops the head word, and that word also appears on the last-read output. The port data shows the FIFO head, or the last-read value when the FIFO is empty. A port read with an empty FIFO pops nothing and changes nothing.
- R6: A port write is accepted only in bulk program mode with the FIFO not full. Any other port write is dropped.
- R7: In bulk program the engine writes the FIFO head to the array at the current address, holds that data until acknowledged, and then pops the word.
- R8: Ready is 0 while a bulk read or bulk program run is in progress. It returns to 1 once the remaining count reaches 0. The mode stays set until software writes standby.
- R9: Writing standby during a run aborts it: ready goes to 1, the remaining count goes to 0 and no further array requests are made.
- R10: A flush pulse leaves the FIFO empty on the next cycle.
- R11: The level output equals the number of words held in the FIFO, from 0 to 8.
- R12: The count register keeps the value software wrote; the logic never modifies it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 3 | Mode code to write |
| addr_wr | input | 1 | Start-address write strobe |
| addr_wdata | input | 14 | Start cell address (bit 0 = upper half) |
| cnt_wr | input | 1 | Word-count write strobe |
| cnt_wdata | input | 14 | Words minus one |
| fifo_flush | input | 1 | Empties the FIFO |
| port_rd | input | 1 | Data port read strobe |
| port_wr | input | 1 | Data port write strobe |
| port_wdata | input | 32 | Data port write value |
| port_rdata | output | 32 | FIFO head, or last-read value when empty |
| last_rdata | output | 32 | Word taken by the latest popping port read |
| mode_q | output | 3 | Current mode code |
| cnt_q | output | 14 | Stored word count |
| remain | output | 15 | Live number of words still to transfer |
| fifo_level | output | 4 | Words held in the FIFO |
| ready | output | 1 | 1 when no bulk run is active |
| arr_req | output | 1 | Array access request, held until acknowledged |
| arr_we | output | 1 | 1 = program access, 0 = read access |
| arr_word | output | 13 | Physical word address |
| arr_hi | output | 1 | Selects the upper 32-bit half |
| arr_wdata | output | 32 | Data to program |
| arr_rdata | input | 32 | Read data, valid with the acknowledge |
| arr_ack | input | 1 | One-cycle access acknowledge |

## Verification
Some properties hold on every cycle and are checked as such:
- The mode lock.
- A busy engine never has a zero remaining count.
- Ready low only in the two bulk modes.
- A request, and its program data, stay stable until acknowledged.
- A flush always empties the FIFO.
- A port write into a full FIFO never raises the level.

Other behaviour needs the bench's scenarios, in which a behavioural model follows every clock:
- The data order across a FIFO-full stall.
- Alternating halves from an odd start address.
- Dropped writes during a back-to-back program burst.
- The final array contents.
- The quiet array interface after an abort.

// File: rtl/otp_bulk_pkg.sv
package otp_bulk_pkg;

    typedef enum logic [2:0] {
        MD_STBY   = 3'd0,
        MD_DREAD  = 3'd1,
        MD_MPROG  = 3'd2,
        MD_BREAD  = 3'd3,
        MD_BPROG  = 3'd4,
        MD_TBLANK = 3'd5,
        MD_TDEC   = 3'd6,
        MD_TWR    = 3'd7
    } xfer_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_READ,
        SQ_PROG,
        SQ_DONE
    } seq_state_e;

endpackage

// File: rtl/otp_xfer_fifo.sv
module otp_xfer_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int LW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);

    logic [DW-1:0] store [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [LW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else if (flush) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (push) wptr <= wptr + PW'(1);
            if (pop)  rptr <= rptr + PW'(1);
            cnt <= cnt + LW'(push) - LW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) store[wptr] <= push_data;
    end

    assign head  = store[rptr];
    assign level = cnt;
    assign full  = (cnt == LW'(DEPTH));
    assign empty = (cnt == '0);

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH)); // R11
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty); // R10

endmodule

// File: rtl/otp_xfer_seq.sv
module otp_xfer_seq
    import otp_bulk_pkg::*;
#(
    parameter int AW = 14,
    parameter int CW = 14,
    localparam int RW = CW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_wr,
    input  logic [2:0]    mode_wdata,
    input  logic [AW-1:0] start_addr,
    input  logic [CW-1:0] word_cnt,
    input  logic          fifo_full,
    input  logic          fifo_empty,
    input  logic          arr_ack,
    output logic [2:0]    mode_q,
    output logic [RW-1:0] remain,
    output logic          ready,
    output logic          arr_req,
    output logic          arr_we,
    output logic [AW-2:0] arr_word,
    output logic          arr_hi,
    output logic          eng_push,
    output logic          eng_pop
);

    seq_state_e    st_q, st_d;
    xfer_mode_e    mode_r, new_mode;
    logic [RW-1:0] remain_q;
    logic [AW-1:0] cur_q;
    logic          accept, abort, start_rd, start_pg, busy, last_word;

    assign new_mode  = xfer_mode_e'(mode_wdata);
    assign accept    = mode_wr && (mode_r == MD_STBY || new_mode == MD_STBY);
    assign abort     = accept && (new_mode == MD_STBY);
    assign start_rd  = accept && (mode_r == MD_STBY) && (new_mode == MD_BREAD);
    assign start_pg  = accept && (mode_r == MD_STBY) && (new_mode == MD_BPROG);
    assign busy      = (st_q == SQ_READ) || (st_q == SQ_PROG);
    assign last_word = arr_ack && (remain_q == RW'(1));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SQ_IDLE: begin
                if (start_rd)      st_d = SQ_READ;
                else if (start_pg) st_d = SQ_PROG;
            end
            SQ_READ, SQ_PROG: begin
                if (abort)          st_d = SQ_IDLE;
                else if (last_word) st_d = SQ_DONE;
            end
            SQ_DONE: begin
                if (abort) st_d = SQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SQ_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_r   <= MD_STBY;
            remain_q <= '0;
            cur_q    <= '0;
        end else begin
            if (accept) mode_r <= new_mode;
            if (abort) begin
                remain_q <= '0;
            end else if (start_rd || start_pg) begin
                remain_q <= RW'(word_cnt) + RW'(1);
                cur_q    <= start_addr;
            end else if (busy && arr_ack) begin
                remain_q <= remain_q - RW'(1);
                cur_q    <= cur_q + AW'(1);
            end
        end
    end

    always_comb begin
        arr_req  = 1'b0;
        arr_we   = 1'b0;
        eng_push = 1'b0;
        eng_pop  = 1'b0;
        ready    = 1'b1;
        unique case (st_q)
            SQ_READ: begin
                arr_req  = !fifo_full;
                eng_push = arr_ack;
                ready    = 1'b0;
            end
            SQ_PROG: begin
                arr_req = !fifo_empty;
                arr_we  = 1'b1;
                eng_pop = arr_ack;
                ready   = 1'b0;
            end
            SQ_IDLE, SQ_DONE: ;
        endcase
    end

    assign mode_q   = mode_r;
    assign remain   = remain_q;
    assign arr_word = cur_q[AW-1:1];
    assign arr_hi   = cur_q[0];

    AST_MODE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_r != MD_STBY) |=> (mode_r == $past(mode_r) || mode_r == MD_STBY)); // R2
    AST_BUSY_HAS_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> remain_q != '0); // R8
    AST_BUSY_IN_BULK: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (mode_r == MD_BREAD || mode_r == MD_BPROG)); // R8
    AST_ABORT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (ready && remain_q == '0 && !arr_req)); // R9

endmodule

// File: rtl/otp_bulk_xfer.sv
module otp_bulk_xfer
    import otp_bulk_pkg::*;
#(
    parameter int ADDR_W     = 14,
    parameter int CNT_W      = 14,
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 8,
    localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1,
    localparam int REM_W     = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [2:0]        mode_wdata,
    input  logic              addr_wr,
    input  logic [ADDR_W-1:0] addr_wdata,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              fifo_flush,
    input  logic              port_rd,
    input  logic              port_wr,
    input  logic [DATA_W-1:0] port_wdata,
    output logic [DATA_W-1:0] port_rdata,
    output logic [DATA_W-1:0] last_rdata,
    output logic [2:0]        mode_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [REM_W-1:0]  remain,
    output logic [LVL_W-1:0]  fifo_level,
    output logic              ready,
    output logic              arr_req,
    output logic              arr_we,
    output logic [ADDR_W-2:0] arr_word,
    output logic              arr_hi,
    output logic [DATA_W-1:0] arr_wdata,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic              arr_ack
);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  count_q;
    logic [DATA_W-1:0] last_q, head;
    logic              full, empty, eng_push, eng_pop, port_push, port_pop;
    logic              in_prog;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            count_q <= '0;
            last_q  <= '0;
        end else begin
            if (addr_wr) addr_q  <= addr_wdata;
            if (cnt_wr)  count_q <= cnt_wdata;
            if (port_pop) last_q <= head;
        end
    end

    assign in_prog   = (mode_q == MD_BPROG);
    assign port_push = port_wr && in_prog && !full && !fifo_flush;
    assign port_pop  = port_rd && !in_prog && !empty && !fifo_flush;

    otp_xfer_seq #(.AW(ADDR_W), .CW(CNT_W)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .start_addr (addr_q),
        .word_cnt   (count_q),
        .fifo_full  (full),
        .fifo_empty (empty),
        .arr_ack    (arr_ack),
        .mode_q     (mode_q),
        .remain     (remain),
        .ready      (ready),
        .arr_req    (arr_req),
        .arr_we     (arr_we),
        .arr_word   (arr_word),
        .arr_hi     (arr_hi),
        .eng_push   (eng_push),
        .eng_pop    (eng_pop)
    );

    otp_xfer_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (fifo_flush),
        .push      (eng_push || port_push),
        .push_data (eng_push ? arr_rdata : port_wdata),
        .pop       (eng_pop || port_pop),
        .head      (head),
        .level     (fifo_level),
        .full      (full),
        .empty     (empty)
    );

    assign port_rdata = empty ? last_q : head;
    assign last_rdata = last_q;
    assign cnt_q      = count_q;
    assign arr_wdata  = head;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_req && !arr_ack && !fifo_flush) |=> (arr_req || mode_q == MD_STBY)); // R3
    AST_PROG_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_req && arr_we && !arr_ack && !fifo_flush) |=> (!arr_req || $stable(arr_wdata))); // R7
    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && in_prog && full && !fifo_flush) |=> fifo_level <= $past(fifo_level)); // R6

endmodule

// File: tb/otp_bulk_xfer_tb_top.sv
module otp_bulk_xfer_tb_top;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr = 0, addr_wr = 0, cnt_wr = 0, fifo_flush = 0, port_rd = 0, port_wr = 0;
    logic [2:0]  mode_wdata = 0;
    logic [13:0] addr_wdata = 0, cnt_wdata = 0;
    logic [31:0] port_wdata = 0;
    logic [31:0] port_rdata, last_rdata, arr_wdata, arr_rdata;
    logic [2:0]  mode_q;
    logic [13:0] cnt_q;
    logic [14:0] remain;
    logic [3:0]  fifo_level;
    logic        ready, arr_req, arr_we, arr_hi, ack_r;
    logic [12:0] arr_word;

    always #4 clk = ~clk;

    otp_bulk_xfer dut_i (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .addr_wr(addr_wr), .addr_wdata(addr_wdata), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .fifo_flush(fifo_flush), .port_rd(port_rd), .port_wr(port_wr), .port_wdata(port_wdata),
        .port_rdata(port_rdata), .last_rdata(last_rdata), .mode_q(mode_q), .cnt_q(cnt_q),
        .remain(remain), .fifo_level(fifo_level), .ready(ready), .arr_req(arr_req),
        .arr_we(arr_we), .arr_word(arr_word), .arr_hi(arr_hi), .arr_wdata(arr_wdata),
        .arr_rdata(arr_rdata), .arr_ack(arr_ack_w)
    );

    // array model: acknowledge one cycle after a request
    logic        arr_ack_w;
    logic [31:0] mem     [256];
    logic [31:0] ref_mem [256];
    assign arr_ack_w = ack_r;
    assign arr_rdata = ack_r ? mem[{arr_word[6:0], arr_hi}] : 32'h0;

    function automatic logic [31:0] init_word(int i);
        return 32'h5A00_0000 ^ (i * 32'h0101_0301);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) ack_r <= 1'b0;
        else begin
            ack_r <= arr_req & ~ack_r;
            if (ack_r && arr_we) mem[{arr_word[6:0], arr_hi}] <= arr_wdata;
        end
    end

    // reference model
    int          vectors = 0, fails = 0, drops = 0;
    int          m_mode, m_st;          // m_st: 0 idle, 1 read, 2 prog, 3 done
    int          m_remain, m_cur, m_addr, m_cnt;
    logic [31:0] m_last;
    logic [31:0] q[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_st = 0; m_remain = 0; m_cur = 0; m_addr = 0; m_cnt = 0;
            m_last = 0; q.delete();
        end else begin
            bit eng_push, eng_pop, p_push, p_pop;
            eng_push = (m_st == 1) && ack_r;
            eng_pop  = (m_st == 2) && ack_r;
            p_push   = port_wr && m_mode == 4 && q.size() < DEPTH;
            p_pop    = port_rd && m_mode != 4 && q.size() > 0;
            if (port_wr && !p_push && m_mode == 4) drops++;
            if (fifo_flush) q.delete();
            else begin
                if (p_pop) begin m_last = q[0]; void'(q.pop_front()); end
                if (eng_pop) begin ref_mem[m_cur % 256] = q[0]; void'(q.pop_front()); end
                if (eng_push) q.push_back(ref_mem[m_cur % 256]);
                if (p_push) q.push_back(port_wdata);
            end
            if ((m_st == 1 || m_st == 2) && ack_r) begin
                m_remain--; m_cur = (m_cur + 1) % 16384;
                if (m_remain == 0) m_st = 3;
            end
            if (mode_wr && (m_mode == 0 || mode_wdata == 0)) begin
                if (mode_wdata == 0) begin m_st = 0; m_remain = 0; end
                else if (mode_wdata == 3 || mode_wdata == 4) begin
                    m_st = (mode_wdata == 3) ? 1 : 2;
                    m_remain = m_cnt + 1; m_cur = m_addr;
                end
                m_mode = mode_wdata;
            end
            if (addr_wr) m_addr = addr_wdata;
            if (cnt_wr)  m_cnt = cnt_wdata;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit m_req;
            m_req = (m_st == 1 && q.size() < DEPTH) || (m_st == 2 && q.size() > 0);
            chk(mode_q == 3'(m_mode), "R2 mode", 32'(mode_q), 32'(m_mode));
            chk(remain == 15'(m_remain), "R3 remain", 32'(remain), 32'(m_remain));
            chk(fifo_level == 4'(q.size()), "R11 level", 32'(fifo_level), 32'(q.size()));
            chk(ready == (m_st != 1 && m_st != 2), "R8 ready", 32'(ready), 32'(m_st != 1 && m_st != 2));
            chk(last_rdata == m_last, "R5 last", last_rdata, m_last);
            chk(port_rdata == (q.size() > 0 ? q[0] : m_last), "R5 port data", port_rdata,
                q.size() > 0 ? q[0] : m_last);
            chk(cnt_q == 14'(m_cnt), "R12 count", 32'(cnt_q), 32'(m_cnt));
            chk(arr_req == m_req, "R4 request", 32'(arr_req), 32'(m_req));
            if (m_req && arr_req) begin
                chk({arr_word, arr_hi} == 14'(m_cur), "R3 address", 32'({arr_word, arr_hi}), 32'(m_cur));
                chk(arr_we == (m_st == 2), "R7 direction", 32'(arr_we), 32'(m_st == 2));
                if (m_st == 2) chk(arr_wdata == q[0], "R7 program data", arr_wdata, q[0]);
            end
        end
    end

    // stimulus helpers
    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
        #1;
    endtask
    task automatic wr_mode(logic [2:0] m);
        mode_wr = 1; mode_wdata = m; step(); mode_wr = 0;
    endtask
    task automatic wr_addr(logic [13:0] a);
        addr_wr = 1; addr_wdata = a; step(); addr_wr = 0;
    endtask
    task automatic wr_cnt(logic [13:0] c);
        cnt_wr = 1; cnt_wdata = c; step(); cnt_wr = 0;
    endtask
    task automatic pop_port();
        port_rd = 1; step(); port_rd = 0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) begin mem[i] = init_word(i); ref_mem[i] = init_word(i); end
        step(4);
        rst_n = 1;
        step();
        // R1 reset state
        chk(mode_q == 0 && remain == 0 && fifo_level == 0 && ready && last_rdata == 0,
            "R1 reset", {mode_q, remain, fifo_level, 10'd0}, 32'h0);

        // R2: direct read code starts nothing and locks out bulk codes
        wr_mode(3'd1);
        wr_mode(3'd3);
        step(3);
        chk(mode_q == 3'd1, "R2 lock", 32'(mode_q), 32'd1);
        chk(!arr_req && ready, "R2 no access", 32'(arr_req), 32'd0);
        wr_mode(3'd0);

        // R6: port write outside bulk program is dropped
        port_wr = 1; port_wdata = 32'hDEAD_0001; step(); port_wr = 0;
        chk(fifo_level == 0, "R6 standby write dropped", 32'(fifo_level), 32'd0);

        // R3/R4/R5 bulk read from odd start address, stall on full
        wr_addr(14'd5);
        wr_cnt(14'd11);
        wr_mode(3'd3);
        step(40);
        chk(fifo_level == 4'd8, "R4 fifo full stall", 32'(fifo_level), 32'd8);
        chk(remain == 15'd4, "R3 remain at stall", 32'(remain), 32'd4);
        chk(!ready, "R8 busy", 32'(ready), 32'd0);
        wr_mode(3'd4);
        chk(mode_q == 3'd3, "R2 mode change rejected", 32'(mode_q), 32'd3);
        for (int i = 0; i < 12; i++) begin
            while (fifo_level == 0) step();
            chk(port_rdata == init_word(5 + i), "R5 read order", port_rdata, init_word(5 + i));
            pop_port();
            chk(last_rdata == init_word(5 + i), "R5 last read", last_rdata, init_word(5 + i));
        end
        step(4);
        chk(ready && remain == 0, "R8 run complete", 32'(ready), 32'd1);
        chk(mode_q == 3'd3, "R8 mode held", 32'(mode_q), 32'd3);
        pop_port();
        chk(last_rdata == init_word(16) && fifo_level == 0, "R5 empty read", last_rdata, init_word(16));
        wr_mode(3'd0);

        // R6/R7 bulk program, back-to-back writes overrun the FIFO
        wr_addr(14'd20);
        wr_cnt(14'd20);
        wr_mode(3'd4);
        for (int k = 0; k < 24; k++) begin
            port_wr = 1; port_wdata = 32'hC0DE_0000 + 32'(k); step();
        end
        port_wr = 0;
        step(100);
        chk(drops > 0, "R6 full write dropped", 32'(drops), 32'd1);
        chk(mem[20] == 32'hC0DE_0000, "R7 first programmed word", mem[20], 32'hC0DE_0000);
        for (int i = 0; i < 256; i++)
            chk(mem[i] == ref_mem[i], "R7 array contents", mem[i], ref_mem[i]);
        wr_mode(3'd0);

        // R9 abort, R10 flush, R12 count held
        wr_addr(14'd0);
        wr_cnt(14'd30);
        wr_mode(3'd3);
        step(6);
        wr_mode(3'd0);
        chk(ready && remain == 0, "R9 abort", 32'(remain), 32'd0);
        for (int i = 0; i < 10; i++) begin
            chk(!arr_req, "R9 quiet after abort", 32'(arr_req), 32'd0);
            step();
        end
        chk(fifo_level != 0, "R10 words before flush", 32'(fifo_level), 32'd1);
        fifo_flush = 1; step(); fifo_flush = 0;
        chk(fifo_level == 0, "R10 flush", 32'(fifo_level), 32'd0);
        chk(cnt_q == 14'd30, "R12 count unchanged", 32'(cnt_q), 32'd30);
        step(3);
        finish_run();
    end

endmodule